// File: doc/BRIEF.md
# Serial Signal Unit Receiver

This block takes a bit-serial line, sampled once per rising edge of the 1x receive clock, and turns the HDLC-framed signal units on it into a byte stream. It finds the flags that bound each unit, and a single flag may close one unit and open the next. It deletes the zeros that the transmitter inserted for transparency and packs the remaining bits into bytes, least significant bit first. The check sequence is verified by comparing the final state of a check register with a fixed residue. The check bytes themselves are never delivered.

Each delivered unit appears as a run of byte beats. The first beat carries a start marker and the last carries an end marker together with a five-bit status. The status reports one verdict (check good, check bad, misaligned or aborted) plus an odd-length flag. Beside the stream, the block signals each abort pattern on the line and holds an idle indication while the line stays at continuous ones. A byte that the consumer cannot take is dropped and reported as an overrun.

Top module: `srx_top`

## Requirements
- R1: A flag is the bit pattern 0,1,1,1,1,1,1,0 in arrival order. The flag that closes a unit also opens the next one, so two units separated by exactly one flag are both delivered.
- R2: Inside a unit, a 0 that arrives directly after five consecutive 1s is removed before byte assembly, so data containing long runs of ones is delivered unchanged.
- R3: Data bytes are assembled LSB first. The first delivered byte of a unit has outSof=1 and the last has outEof=1. The check bytes are not delivered, and outStatus is zero on every beat that does not carry outEof.
- R4: With crcWide=0 (16-bit check, reflected polynomial 0x8408, register preset to all ones at every flag), a unit whose check register, bit-reversed, equals 0x1D0F at the closing flag ends with outStatus bit 0 (good) set.
- R5: With crcWide=1 (32-bit check, reflected polynomial 0xEDB88320, preset to all ones), a bit-reversed register equal to 0xC704DD7B at the closing flag gives outStatus bit 0 (good).
- R6: An aligned unit whose residue does not match ends with outStatus bit 1 (bad). Every end beat carries exactly one of bits 0 to 3.
- R7: A unit whose destuffed bit count between flags is not a multiple of 8 ends with outStatus bit 2 (misaligned) and neither check bit set.
- R8: outStatus bit 4 (odd length) is set on the end beat of a closed unit when the number of delivered data bytes is odd.
- R9: Seven consecutive 1s raise lineAbort for one cycle. A unit that has already reached the minimum length is closed by a final beat with outEof=1 and outStatus=0x08. A shorter unit is dropped.
- R10: lineIdle is 1 after fifteen or more consecutive 1s and returns to 0 after the next 0. It is 0 after fourteen 1s.
- R11: A unit with fewer whole bytes than the check length plus one produces no beat and no overrun.
- R12: A byte that becomes ready while outReady=0 is not presented. Instead, overrun pulses for one cycle, and outValid and overrun are never high together.
- R13: During and right after reset, outValid, overrun, lineAbort and lineIdle are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1x receive clock; rxBit is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rxBit | input | 1 | Serial receive data |
| crcWide | input | 1 | 0 selects the 16-bit check, 1 the 32-bit check; changed only between units |
| outReady | input | 1 | Consumer can accept a byte this cycle |
| outValid | output | 1 | A byte beat is presented |
| outByte | output | 8 | Received data byte |
| outSof | output | 1 | First byte of a unit |
| outEof | output | 1 | Last byte of a unit; outStatus is valid |
| outStatus | output | 5 | bit0 good, bit1 bad, bit2 misaligned, bit3 aborted, bit4 odd length |
| overrun | output | 1 | A byte was dropped because outReady was low |
| lineAbort | output | 1 | One-cycle pulse on seven consecutive ones |
| lineIdle | output | 1 | Line has shown fifteen or more consecutive ones |

## Verification
The assertions watch, on every cycle, the invariants that tie the outputs together. Exactly one verdict accompanies each end beat, status stays clear on middle beats, a beat and an overrun never coincide, an aborted end beat lines up with the abort pulse, and no data bit is accepted while the line is idle. Whether a delivered byte is correct, whether check bytes are stripped, and whether the residue compare picks the right verdict can only be shown by the bench. It builds stuffed units at both check widths and many lengths, then adds shared flags, corrupted checks, extra tail bits, aborts, short units, a stalled consumer and an idle line.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Strobes from bit-level control to the byte datapath
  typedef struct packed {
    logic push;     // a destuffed data bit leaves the flag delay line
    logic pushBit;  // value of that bit
    logic open;     // any flag seen: restart unit state
    logic close;    // flag seen while a unit was open
    logic abort;    // seven ones seen while a unit was open
  } srx_strobe_t;

  // Per-unit status, crcGood in bit 0
  typedef struct packed {
    logic oddLen;
    logic aborted;
    logic misaligned;
    logic crcBad;
    logic crcGood;
  } srx_status_t;

  localparam int STATUS_W = $bits(srx_status_t);

  localparam int          NARROW_W   = 16;
  localparam int          WIDE_W     = 32;
  localparam logic [15:0] NARROW_POLY = 16'h8408;
  localparam logic [15:0] NARROW_RES  = 16'h1D0F;
  localparam logic [31:0] WIDE_POLY   = 32'hEDB88320;
  localparam logic [31:0] WIDE_RES    = 32'hC704DD7B;

endpackage

// File: rtl/srx_crc.sv
module srx_crc #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         preset,
  input  logic         step,
  input  logic         bitIn,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = state[0] ^ bitIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= '1;
    end else if (preset) begin
      state <= '1;
    end else if (step) begin
      state <= (state >> 1) ^ (fb ? POLY : '0);
    end
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int RUN_W    = 4,
  parameter int IDLE_RUN = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBit,
  output srx_strobe_t strobe,
  output logic        lineAbort,
  output logic        lineIdle
);
  localparam int DLY    = 7;               // flag bits that precede the final 0
  localparam int FILL_W = $clog2(DLY + 1);
  localparam logic [RUN_W-1:0]  STUFF_RUN = RUN_W'(5);
  localparam logic [RUN_W-1:0]  FLAG_RUN  = RUN_W'(6);
  localparam logic [RUN_W-1:0]  IDLE_MAX  = RUN_W'(IDLE_RUN);
  localparam logic [RUN_W-1:0]  IDLE_PRE  = RUN_W'(IDLE_RUN - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DLY);

  logic [RUN_W-1:0]  onesRun;
  logic              inFrame;
  logic [DLY-1:0]    dly;
  logic [FILL_W-1:0] fill;

  logic isFlag, isStuff, isAbort, accept;

  always_comb begin
    isFlag  = !rxBit && (onesRun == FLAG_RUN);
    isStuff = !rxBit && (onesRun == STUFF_RUN);
    isAbort =  rxBit && (onesRun == FLAG_RUN);
    accept  = inFrame && !isFlag && !isStuff && !isAbort;

    strobe.push    = accept && (fill == FILL_FULL);
    strobe.pushBit = dly[DLY-1];
    strobe.open    = isFlag;
    strobe.close   = isFlag && inFrame;
    strobe.abort   = isAbort && inFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesRun   <= '0;
      inFrame   <= 1'b0;
      dly       <= '0;
      fill      <= '0;
      lineAbort <= 1'b0;
      lineIdle  <= 1'b0;
    end else begin
      if (!rxBit)                 onesRun <= '0;
      else if (onesRun != IDLE_MAX) onesRun <= onesRun + 1'b1;

      if (isFlag) begin
        inFrame <= 1'b1;
        fill    <= '0;
      end else if (isAbort) begin
        inFrame <= 1'b0;
        fill    <= '0;
      end else if (accept) begin
        dly <= {dly[DLY-2:0], rxBit};
        if (fill != FILL_FULL) fill <= fill + 1'b1;
      end

      lineAbort <= isAbort;
      lineIdle  <= rxBit && (onesRun >= IDLE_PRE);
    end
  end

  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    lineIdle |-> !strobe.push) else $error("data accepted on idle line"); // R10

  AST_ABORT_LEAVES_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    lineAbort |-> !inFrame) else $error("unit still open after abort"); // R9

endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int MAX_CK = 4   // check bytes of the wide check
) (
  input  logic                clk,
  input  logic                rstN,
  input  srx_strobe_t         strobe,
  input  logic                crcWide,
  input  logic                outReady,
  output logic                outValid,
  output logic [7:0]          outByte,
  output logic                outSof,
  output logic                outEof,
  output srx_status_t         outStatus,
  output logic                overrun
);
  localparam int NARROW_CK = NARROW_W / 8;
  localparam int HOLD      = MAX_CK + 1;
  localparam int CNT_W     = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] DEPTH_N = CNT_W'(NARROW_CK + 1);
  localparam logic [CNT_W-1:0] DEPTH_W = CNT_W'(MAX_CK + 1);

  logic [7:0]       shiftByte;
  logic [2:0]       bitPos;
  logic [7:0]       held [HOLD];
  logic [CNT_W-1:0] cnt;
  logic             sofDone;
  logic             parity;

  logic [NARROW_W-1:0] crcN, revN;
  logic [WIDE_W-1:0]   crcW, revW;

  srx_crc #(.W(NARROW_W), .POLY(NARROW_POLY)) uCrcN (
    .clk(clk), .rstN(rstN), .preset(strobe.open), .step(strobe.push),
    .bitIn(strobe.pushBit), .state(crcN));

  srx_crc #(.W(WIDE_W), .POLY(WIDE_POLY)) uCrcW (
    .clk(clk), .rstN(rstN), .preset(strobe.open), .step(strobe.push),
    .bitIn(strobe.pushBit), .state(crcW));

  always_comb begin
    for (int k = 0; k < NARROW_W; k++) revN[k] = crcN[NARROW_W-1-k];
    for (int k = 0; k < WIDE_W; k++)   revW[k] = crcW[WIDE_W-1-k];
  end

  logic [CNT_W-1:0] depth;
  logic [7:0]       newByte, oldest;
  logic             byteDone, full, emitData, emitEnd, residueOk;
  srx_status_t      endStatus;

  always_comb begin
    depth     = crcWide ? DEPTH_W : DEPTH_N;
    newByte   = {strobe.pushBit, shiftByte[7:1]};
    byteDone  = strobe.push && (bitPos == 3'd7);
    full      = (cnt == depth);
    oldest    = crcWide ? held[MAX_CK] : held[NARROW_CK];
    emitData  = byteDone && full;
    emitEnd   = (strobe.close || strobe.abort) && full;
    residueOk = crcWide ? (revW == WIDE_RES) : (revN == NARROW_RES);

    endStatus = '0;
    if (strobe.abort) begin
      endStatus.aborted = 1'b1;
    end else begin
      endStatus.misaligned = (bitPos != 3'd0);
      endStatus.crcGood    = (bitPos == 3'd0) && residueOk;
      endStatus.crcBad     = (bitPos == 3'd0) && !residueOk;
      endStatus.oddLen     = parity;
    end
  end

  // holding line: newest at index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         held[0] <= '0;
    else if (byteDone) held[0] <= newByte;
  end

  generate
    for (genvar i = 1; i < HOLD; i++) begin : gHold
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         held[i] <= '0;
        else if (byteDone) held[i] <= held[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftByte <= '0;
      bitPos    <= '0;
      cnt       <= '0;
      sofDone   <= 1'b0;
      parity    <= 1'b0;
    end else if (strobe.open || strobe.abort) begin
      bitPos  <= '0;
      cnt     <= '0;
      sofDone <= 1'b0;
      parity  <= 1'b0;
    end else if (strobe.push) begin
      shiftByte <= newByte;
      bitPos    <= bitPos + 3'd1;
      if (byteDone) begin
        parity <= ~parity;
        if (!full) cnt <= cnt + 1'b1;
        if (full)  sofDone <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outByte   <= '0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outStatus <= '0;
      overrun   <= 1'b0;
    end else begin
      outValid  <= 1'b0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outStatus <= '0;
      overrun   <= 1'b0;
      if (emitData || emitEnd) begin
        if (outReady) begin
          outValid  <= 1'b1;
          outByte   <= oldest;
          outSof    <= !sofDone;
          outEof    <= emitEnd;
          outStatus <= emitEnd ? endStatus : '0;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  AST_VALID_OR_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && overrun)) else $error("beat and overrun together"); // R12

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEof) |-> $countones({outStatus.aborted, outStatus.misaligned,
                                         outStatus.crcBad, outStatus.crcGood}) == 1)
    else $error("end beat without a single verdict"); // R6

  AST_MID_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outEof) |-> (outStatus == '0)) else $error("status on middle beat"); // R3

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int MAX_CK   = 4,
  parameter int RUN_W    = 4,
  parameter int IDLE_RUN = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       crcWide,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outByte,
  output logic       outSof,
  output logic       outEof,
  output logic [4:0] outStatus,
  output logic       overrun,
  output logic       lineAbort,
  output logic       lineIdle
);
  srx_strobe_t strobe;
  srx_status_t status;

  srx_ctrl #(.RUN_W(RUN_W), .IDLE_RUN(IDLE_RUN)) uCtrl (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strobe(strobe),
    .lineAbort(lineAbort), .lineIdle(lineIdle));

  srx_dpath #(.MAX_CK(MAX_CK)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .crcWide(crcWide),
    .outReady(outReady), .outValid(outValid), .outByte(outByte),
    .outSof(outSof), .outEof(outEof), .outStatus(status), .overrun(overrun));

  assign outStatus = status;

  AST_ABORT_WITH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus[3]) |-> lineAbort) else $error("aborted beat without abort pulse"); // R9

endmodule

// File: tb/sim_srx_top.sv
`timescale 1ns/1ps
module sim_srx_top;
  logic clk = 1'b0;
  logic rstN, rxBit, crcWide, outReady;
  logic outValid, outSof, outEof, overrun, lineAbort, lineIdle;
  logic [7:0] outByte;
  logic [4:0] outStatus;

  always #2 clk = ~clk;

  srx_top u0 (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .crcWide(crcWide), .outReady(outReady),
    .outValid(outValid), .outByte(outByte), .outSof(outSof), .outEof(outEof),
    .outStatus(outStatus), .overrun(overrun), .lineAbort(lineAbort), .lineIdle(lineIdle));

  int nChecks = 0, nFail = 0;
  int benchOnes = 0;

  logic [14:0] expBeat [0:255];
  logic [14:0] capBeat [0:255];
  int expN = 0, capN = 0, ovrCnt = 0, abortCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && capN < 256) begin
        capBeat[capN] = {outStatus, outEof, outSof, outByte};
        capN++;
      end
      if (overrun)   ovrCnt++;
      if (lineAbort) abortCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearCap();
    expN = 0; capN = 0; ovrCnt = 0; abortCnt = 0;
  endtask

  task automatic sendBit(input logic b);
    rxBit = b;
    @(negedge clk);
  endtask

  task automatic stuffBit(input logic b);
    sendBit(b);
    if (b) begin
      benchOnes++;
      if (benchOnes == 5) begin
        sendBit(1'b0);
        benchOnes = 0;
      end
    end else begin
      benchOnes = 0;
    end
  endtask

  task automatic sendFlag();
    sendBit(1'b0);
    for (int k = 0; k < 6; k++) sendBit(1'b1);
    sendBit(1'b0);
    benchOnes = 0;
  endtask

  task automatic sendAbort();
    sendBit(1'b0);
    for (int k = 0; k < 7; k++) sendBit(1'b1);
    benchOnes = 0;
  endtask

  task automatic stuffByte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) stuffBit(v[k]);
  endtask

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] v, input bit wide);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ v[k];
      r = r >> 1;
      if (fb) r = r ^ (wide ? 32'hEDB88320 : 32'h00008408);
    end
    return r;
  endfunction

  function automatic logic [7:0] patByte(input int seed, input int i);
    if (i == 0) return 8'hFF;
    return 8'(seed * 59 + i * 109) ^ 8'h7E;
  endfunction

  task automatic pushExp(input logic [7:0] b, input bit s, input bit e, input logic [4:0] st);
    expBeat[expN] = {st, e, s, b};
    expN++;
  endtask

  // Sends one unit body (no flags) and records the beats it must produce.
  task automatic sendBody(input int len, input int seed, input bit wide, input bit withFcs,
                          input bit corrupt, input int extra, input bit willAbort);
    int ck, depth, whole, m;
    logic [31:0] c, fcs;
    logic [4:0] st;
    ck = wide ? 4 : 2;
    depth = ck + 1;
    whole = len + (withFcs ? ck : 0);
    if (whole >= depth) begin
      if (willAbort) begin
        m = whole - depth + 1;
        for (int i = 0; i < m; i++)
          pushExp(patByte(seed, i), i == 0, i == m - 1, (i == m - 1) ? 5'h08 : 5'h00);
      end else begin
        st = (extra != 0) ? 5'h04 : (corrupt ? 5'h02 : 5'h01);
        if (len % 2 == 1) st = st | 5'h10;
        for (int i = 0; i < len; i++)
          pushExp(patByte(seed, i), i == 0, i == len - 1, (i == len - 1) ? st : 5'h00);
      end
    end
    c = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i < len; i++) begin
      stuffByte(patByte(seed, i));
      c = crcByte(c, patByte(seed, i), wide);
    end
    if (withFcs) begin
      fcs = ~c;
      if (corrupt) fcs[0] = ~fcs[0];
      for (int j = 0; j < ck; j++) stuffByte(fcs[8*j +: 8]);
    end
    for (int k = 0; k < extra; k++) stuffBit(1'b0);
  endtask

  task automatic compareCap(input string tag);
    int n;
    check(capN == expN, tag, capN, expN);
    n = (capN < expN) ? capN : expN;
    for (int i = 0; i < n; i++)
      check(capBeat[i] === expBeat[i], tag, int'(capBeat[i]), int'(expBeat[i]));
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; rxBit = 1'b0; crcWide = 1'b0; outReady = 1'b1;
    repeat (4) @(negedge clk);
    // R13: reset state
    check(outValid == 0 && overrun == 0, "R13 reset outputs", {outValid, overrun}, 0);
    check(lineAbort == 0 && lineIdle == 0, "R13 reset line", {lineAbort, lineIdle}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && overrun == 0 && lineIdle == 0, "R13 after reset",
          {outValid, overrun, lineIdle}, 0);

    // R3 R4 R5 R8 R2: sweep lengths at both check widths
    for (int w = 0; w < 2; w++) begin
      crcWide = w[0];
      for (int len = 1; len <= 7; len++) begin
        clearCap();
        sendFlag();
        sendBody(len, len + 3 * w, w[0], 1'b1, 1'b0, 0, 1'b0);
        sendFlag(); sendFlag();
        compareCap(w ? "R5 R3 R8 R2 wide sweep" : "R4 R3 R8 R2 narrow sweep");
      end
    end

    // R1: shared flag between two units
    crcWide = 1'b0;
    clearCap();
    sendFlag();
    sendBody(3, 11, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    sendFlag();
    sendBody(4, 12, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    sendFlag(); sendFlag();
    compareCap("R1 shared flag");

    // R6: corrupted check at both widths
    for (int w = 0; w < 2; w++) begin
      crcWide = w[0];
      clearCap();
      sendFlag();
      sendBody(4 - w, 20 + w, w[0], 1'b1, 1'b1, 0, 1'b0);
      sendFlag(); sendFlag();
      compareCap("R6 bad check");
    end

    // R7: extra tail bits make the unit misaligned
    for (int w = 0; w < 2; w++) begin
      crcWide = w[0];
      clearCap();
      sendFlag();
      sendBody(3 - w, 30 + w, w[0], 1'b1, 1'b0, 3 + 2 * w, 1'b0);
      sendFlag(); sendFlag();
      compareCap("R7 misaligned");
    end

    // R9: abort of a started unit and of a short one
    crcWide = 1'b0;
    clearCap();
    sendFlag();
    sendBody(6, 40, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    sendAbort();
    sendFlag(); sendFlag();
    compareCap("R9 abort started unit");
    check(abortCnt == 1, "R9 abort pulse count", abortCnt, 1);
    clearCap();
    sendFlag();
    sendBody(2, 41, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    sendAbort();
    sendFlag(); sendFlag();
    compareCap("R9 abort short unit");

    // R11: units below the minimum length
    for (int w = 0; w < 2; w++) begin
      crcWide = w[0];
      clearCap();
      sendFlag();
      sendBody(0, 50, w[0], 1'b1, 1'b0, 0, 1'b0);
      sendFlag(); sendFlag(); sendFlag();
      check(capN == 0 && ovrCnt == 0, "R11 short unit dropped", capN + ovrCnt, 0);
    end

    // R12: consumer not ready
    crcWide = 1'b0;
    clearCap();
    outReady = 1'b0;
    sendFlag();
    sendBody(3, 60, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    sendFlag(); sendFlag();
    outReady = 1'b1;
    check(capN == 0, "R12 no beat while not ready", capN, 0);
    check(ovrCnt == 3, "R12 overrun count", ovrCnt, 3);
    clearCap();
    sendFlag();
    sendBody(2, 61, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    sendFlag(); sendFlag();
    compareCap("R12 recovery after overrun");

    // R10: idle line
    clearCap();
    sendFlag();
    for (int k = 0; k < 14; k++) sendBit(1'b1);
    check(lineIdle == 0, "R10 fourteen ones", lineIdle, 0);
    sendBit(1'b1);
    check(lineIdle == 1, "R10 fifteen ones", lineIdle, 1);
    sendBit(1'b1);
    check(lineIdle == 1, "R10 sixteen ones", lineIdle, 1);
    sendBit(1'b0);
    check(lineIdle == 0, "R10 zero ends idle", lineIdle, 0);
    check(abortCnt == 1 && capN == 0, "R9 R10 single abort on idle", abortCnt, 1);
    sendFlag();

    finishRun();
  end
endmodule